// File: doc/BRIEF.md
# Cascaded Seven-Channel DMA Request Arbiter

This block decides which peripheral gets the shared transfer engine next. Eight request slots are arranged as two four-input priority stages. The lower stage covers channels 0 to 3, which move 8 bits per unit. The upper stage covers channels 5 to 7, which move 16 bits per unit. Slot 0 of the upper stage carries the lower stage's "any request" signal, so channel 4 is reserved for the cascade and is never a user channel.

A peripheral raises its request line and waits for the acknowledge on its own line. The transfer engine reads three things from the arbiter: a grant-valid flag, the 3-bit channel number, and a width flag.

A small two-state machine controls the grant:
- **ARB_IDLE**: the arbiter picks the best eligible request.
  - Transition *pick*: ARB_IDLE to ARB_GRANT when any channel is eligible.
- **ARB_GRANT**: the grant is held.
  - Transition *release*: ARB_GRANT to ARB_IDLE when the engine reports unit-done, or when the sampled request of the granted channel goes low.

Two inputs restrict which channels are eligible:
- A CPU-written mask blocks channels.
- A memory-copy mode limits eligibility to the channel 0/1 pair.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant_vld`, `grant_ch`, `grant_wide` and `dack` are all 0, and every channel's mask bit is set, so no request is granted before the first mask write.
- R2: Request lines are registered once. A lone unmasked request present before clock edge k is granted from edge k+1 onward: `grant_vld`=1, `grant_ch` = the channel number, and `dack` bit = the channel number.
- R3: Priority is fixed. Among channels 0 to 3 the lowest number wins. Any request on channels 0 to 3 beats channels 5 to 7. Among channels 5 to 7 the lowest number wins.
- R4: Channel 4 is never granted, and `dack[4]` is always 0, even when `drq[4]` is high and unmasked.
- R5: While granted, `grant_wide` is 0 for channels 0 to 3 and 1 for channels 5 to 7. It is 0 when no grant is held.
- R6: A held grant keeps the same channel while that channel's sampled request stays high and `unit_done` is low. A higher-priority request arriving meanwhile does not preempt it.
- R7: Release happens in two ways. `unit_done` high at an edge drops the grant at that edge. A request dropping before edge k drops the grant at edge k+1.
- R8: After a release, the machine spends one cycle in ARB_IDLE. At the following edge it grants the best request pending at that moment.
- R9: A `mask_wr` pulse loads `mask_wdata` at the edge; bit i = 1 blocks channel i. A masked channel is never newly granted.
- R10: While `mem_copy` is high, only channels 0 and 1 can be newly granted.
- R11: `dack` is all-zero when there is no grant. Otherwise it has exactly one bit set, at position `grant_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drq | input | 8 | Request lines, bit i = channel i (bit 4 ignored) |
| mask_wr | input | 1 | Load the mask register |
| mask_wdata | input | 8 | New mask value, bit i = 1 blocks channel i |
| mem_copy | input | 1 | Memory-copy mode: only channels 0 and 1 eligible |
| unit_done | input | 1 | Engine finished the current unit, release grant |
| grant_vld | output | 1 | A channel holds the grant |
| grant_ch | output | 3 | Granted channel number (0 when idle) |
| grant_wide | output | 1 | 1 = 16-bit channel granted |
| dack | output | 8 | Acknowledge, one bit per channel |

## Verification
The bench builds the arbiter with its default group size of four. This gives eight slots, with the cascade in slot 4, the 8/16-bit boundary between slots 3 and 5, and the copy pair at slots 0 and 1. With this size, random request patterns reach every cross-stage priority case, including the reserved slot being requested. Fast unit-done pulses and request drops also put releases and re-arbitration next to one another.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_t;

endpackage

// File: rtl/prio_stage.sv
module prio_stage #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/req_gate.sv
module req_gate #(
    parameter int NCH       = 8,
    parameter int CASC_SLOT = 4,
    parameter int COPY_CH   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] drq,
    input  logic           mask_wr,
    input  logic [NCH-1:0] mask_wdata,
    input  logic           mem_copy,
    output logic [NCH-1:0] drq_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] elig
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drq_q  <= '0;
            mask_q <= '1;
        end else begin
            drq_q <= drq;
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_elig
        if (g == CASC_SLOT) begin : g_casc
            assign elig[g] = 1'b0;
        end else if (g < COPY_CH) begin : g_pair
            assign elig[g] = drq_q[g] & ~mask_q[g];
        end else begin : g_plain
            assign elig[g] = drq_q[g] & ~mask_q[g] & ~mem_copy;
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int GRP = 4,
    localparam int NCH = 2 * GRP,
    localparam int CW  = $clog2(NCH),
    localparam int IW  = $clog2(GRP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] drq,
    input  logic           mask_wr,
    input  logic [NCH-1:0] mask_wdata,
    input  logic           mem_copy,
    input  logic           unit_done,
    output logic           grant_vld,
    output logic [CW-1:0]  grant_ch,
    output logic           grant_wide,
    output logic [NCH-1:0] dack
);
    localparam int CASC = GRP;

    logic [NCH-1:0] drq_q, mask_q, elig;
    logic           lo_any, up_any;
    logic [IW-1:0]  lo_idx, up_idx;
    logic [GRP-1:0] up_req;
    logic [CW-1:0]  win_ch, cur_ch;
    arb_state_t     state;

    req_gate #(.NCH(NCH), .CASC_SLOT(CASC), .COPY_CH(2)) u_gate (
        .clk(clk), .rst_n(rst_n), .drq(drq), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .mem_copy(mem_copy),
        .drq_q(drq_q), .mask_q(mask_q), .elig(elig)
    );

    prio_stage #(.N(GRP)) u_lower (
        .req(elig[GRP-1:0]), .any(lo_any), .idx(lo_idx)
    );

    // slot 0 of the upper stage is the cascade from the lower stage
    assign up_req = {elig[NCH-1:GRP+1], lo_any};

    prio_stage #(.N(GRP)) u_upper (
        .req(up_req), .any(up_any), .idx(up_idx)
    );

    assign win_ch = (up_idx == '0) ? CW'(lo_idx) : CW'(CASC) + CW'(up_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ARB_IDLE;
            cur_ch <= '0;
        end else begin
            unique case (state)
                ARB_IDLE: begin
                    if (up_any) begin
                        state  <= ARB_GRANT;
                        cur_ch <= win_ch;
                    end
                end
                ARB_GRANT: begin
                    if (unit_done || !drq_q[cur_ch]) state <= ARB_IDLE;
                end
                default: state <= ARB_IDLE;
            endcase
        end
    end

    always_comb begin
        grant_vld  = 1'b0;
        grant_ch   = '0;
        grant_wide = 1'b0;
        dack       = '0;
        unique case (state)
            ARB_IDLE: ;
            ARB_GRANT: begin
                grant_vld      = 1'b1;
                grant_ch       = cur_ch;
                grant_wide     = (cur_ch > CW'(CASC));
                dack[cur_ch]   = 1'b1;
            end
            default: ;
        endcase
    end

    AST_NO_CASCADE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (grant_ch != CW'(CASC) && !dack[CASC])); // R4
    AST_DACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack) && (grant_vld == (dack != '0))); // R11
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && drq_q[grant_ch] && !unit_done) |=> (grant_vld && $stable(grant_ch))); // R6
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && unit_done) |=> !grant_vld); // R7
    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld) |-> ((($past(elig) >> grant_ch) & NCH'(1)) != '0)); // R9
    AST_COPY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(grant_vld) && $past(mem_copy)) |-> (grant_ch < CW'(2))); // R10
endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] drq = '0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       mem_copy = 1'b0;
    logic       unit_done = 1'b0;
    logic       grant_vld;
    logic [2:0] grant_ch;
    logic       grant_wide;
    logic [7:0] dack;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench model state
    bit       m_vld = 1'b0;
    bit [2:0] m_ch = '0;
    bit [7:0] m_drqq = '0;
    bit [7:0] m_mask = 8'hFF;

    always #4 clk = ~clk;

    dma_req_arbiter dut (
        .clk(clk), .rst_n(rst_n), .drq(drq), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .mem_copy(mem_copy), .unit_done(unit_done),
        .grant_vld(grant_vld), .grant_ch(grant_ch), .grant_wide(grant_wide),
        .dack(dack)
    );

    // fixed priority from R3, channel 4 excluded by R4; returns {found, ch}
    function automatic bit [3:0] pick(input bit [7:0] e);
        for (int i = 0; i < 4; i++) if (e[i]) return {1'b1, 3'(i)};
        for (int i = 5; i < 8; i++) if (e[i]) return {1'b1, 3'(i)};
        return 4'd0;
    endfunction

    function automatic bit [7:0] eligible(input bit [7:0] rq, input bit [7:0] mk, input bit cp);
        return rq & ~mk & 8'hEF & (cp ? 8'h03 : 8'hFF);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "grant_vld", grant_vld, m_vld);
        chk(tag, "grant_ch", grant_ch, m_vld ? m_ch : 0);
        chk("R5", "grant_wide", grant_wide, (m_vld && m_ch > 4) ? 1 : 0);
        chk("R11", "dack", dack, m_vld ? (1 << m_ch) : 0);
    endtask

    // advance one edge, update the model with the inputs seen at that edge
    task automatic step(input string tag);
        bit [3:0] w;
        @(posedge clk);
        if (!rst_n) begin
            m_vld = 0; m_ch = 0; m_drqq = 0; m_mask = 8'hFF;
        end else begin
            if (m_vld) begin
                if (unit_done || !m_drqq[m_ch]) m_vld = 0;
            end else begin
                w = pick(eligible(m_drqq, m_mask, mem_copy));
                if (w[3]) begin m_vld = 1; m_ch = w[2:0]; end
            end
            m_drqq = drq;
            if (mask_wr) m_mask = mask_wdata;
        end
        #1;
        compare(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(64'd8 * 64'd200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        step("R1");
        step("R1");
        rst_n = 1'b1;
        step("R1");
        chk("R1", "idle after reset", grant_vld, 0);
        // R1: masked by default, requests ignored
        drq = 8'hFF;
        repeat (3) step("R1");
        chk("R1", "no grant while all masked", grant_vld, 0);
        drq = 8'h00;
        mask_wr = 1'b1; mask_wdata = 8'h00;
        step("R9");
        mask_wr = 1'b0;
        step("R9");
        // R2: lone request on channel 6
        drq = 8'h40;
        step("R2");
        step("R2");
        chk("R2", "channel 6 granted", grant_ch, 6);
        chk("R5", "channel 6 wide", grant_wide, 1);
        // R6: higher priority arrives, no preemption
        drq = 8'h41;
        repeat (3) step("R6");
        chk("R6", "still channel 6", grant_ch, 6);
        // R7/R8: unit_done releases, then channel 0 wins
        unit_done = 1'b1;
        step("R7");
        chk("R7", "released by unit_done", grant_vld, 0);
        unit_done = 1'b0;
        step("R8");
        chk("R8", "channel 0 after release", grant_ch, 0);
        // R7: drop request
        drq = 8'h40;
        step("R7");
        step("R7");
        step("R8");
        chk("R8", "back to channel 6", grant_ch, 6);
        drq = 8'h00;
        repeat (3) step("R7");
        // R4: cascade slot request ignored
        drq = 8'h10;
        repeat (4) step("R4");
        chk("R4", "slot 4 never granted", grant_vld, 0);
        // R3: cross-stage priority
        drq = 8'hE8;
        repeat (2) step("R3");
        chk("R3", "channel 3 beats 5..7", grant_ch, 3);
        drq = 8'h00;
        repeat (3) step("R3");
        // R10: memory-copy mode
        mem_copy = 1'b1;
        drq = 8'hE6;
        repeat (2) step("R10");
        chk("R10", "copy pair channel 1", grant_ch, 1);
        drq = 8'h00;
        repeat (3) step("R10");
        mem_copy = 1'b0;
        // R9: masked channel skipped
        mask_wr = 1'b1; mask_wdata = 8'h21;
        drq = 8'h00;
        step("R9");
        mask_wr = 1'b0;
        drq = 8'h61;
        repeat (2) step("R9");
        chk("R9", "masked 0 and 5 skipped", grant_ch, 6);
        drq = 8'h00;
        repeat (3) step("R9");
        // random phase
        for (int n = 0; n < 4000; n++) begin
            drq       = 8'($urandom) & 8'($urandom);
            unit_done = ($urandom % 6) == 0;
            mem_copy  = ($urandom % 10) == 0;
            mask_wr   = ($urandom % 25) == 0;
            mask_wdata = 8'($urandom) & 8'($urandom);
            step("R3");
        end
        finish_run();
    end
endmodule